// File: doc/BRIEF.md
# Alarm Window Event Generator with Direction-Dependent Hysteresis

This block takes a stream of signed temperature samples and sets three alarm flags from them: under the lower limit, over the upper limit and over the critical limit. It also drives one event output from those flags. Each sample is checked against its limits at the clock edge where the sample strobe is high. The flags and the event become visible in the next cycle.

Hysteresis depends on the direction the temperature is moving. The block compares each sample with the one before it. When the temperature is falling, the hysteresis amount is subtracted from the limits. When it is rising, the limits are used as given. While the shutdown input is high, the block holds every output low and ignores samples. The direction is unknown on the first sample after reset or shutdown, so that sample uses a fixed rule: hysteresis on the lower limit only.

In comparator mode the event simply follows the flags. In interrupt mode the event latches and stays high until a clear pulse arrives.

Top module: `alarm_window_evt`

## Requirements
- R1: After synchronous reset, all three flags, `evt_out` and `evt_status` are 0.
- R2: While `shdn` is 1, the flags and `evt_out` are 0 and samples are ignored. After `shdn` falls, `evt_out` stays 0 until a new sample says otherwise.
- R3: On the first sample after reset or after shutdown, `flag_below` uses `lim_lo - hyst`, and `flag_above` and `flag_crit` use `lim_hi` and `lim_crit` unchanged.
- R4: From the second sample on, the trend is falling if the sample is below the previous one and rising if it is above. An equal sample keeps the previous trend; before any trend is known, equal counts as rising. When falling, `hyst` is subtracted from all three limits. When rising, no hysteresis is applied.
- R5: All comparisons are strict and use two's complement values: `flag_below` = temp < eff_lo, `flag_above` = temp > eff_hi, `flag_crit` = temp > eff_crit.
- R6: In comparator mode (`mode_intr`=0), each sample sets `evt_out` to the OR of the three new flags, and `clr_evt` has no effect.
- R7: In interrupt mode (`mode_intr`=1), a sample with any flag set makes `evt_out` 1. `evt_out` then stays 1 until a `clr_evt` pulse clears it. If a clear and a flagging sample arrive in the same cycle, the sample wins.
- R8: `evt_status` always equals `evt_out`.
- R9: The flags and the event change exactly one cycle after the edge that captures the sample.
- R10: In cycles without `smp_vld`, the flags keep their values whatever `temp` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | New temperature sample strobe |
| temp | input | TEMP_W | Signed sample value |
| lim_lo | input | TEMP_W | Signed lower limit |
| lim_hi | input | TEMP_W | Signed upper limit |
| lim_crit | input | TEMP_W | Signed critical limit |
| hyst | input | HYST_W | Unsigned hysteresis amount |
| mode_intr | input | 1 | 1 = latched interrupt mode, 0 = comparator mode |
| shdn | input | 1 | Shutdown level |
| clr_evt | input | 1 | Clear pulse for a latched event |
| flag_below | output | 1 | Sample under effective lower limit |
| flag_above | output | 1 | Sample over effective upper limit |
| flag_crit | output | 1 | Sample over effective critical limit |
| evt_out | output | 1 | Event output |
| evt_status | output | 1 | Mirror of the driven event level |

## Verification
The bench goes after these corner cases:
- Samples exactly at each limit, and inside the hysteresis band on both falling and rising runs. A design that compares non-strictly, or applies hysteresis on rising temperature, sets a flag one step too early.
- Repeated equal samples. A design that resets the trend on an equal sample drops the falling band.
- The first sample after waking from shutdown. A design that treats it as falling shifts the upper limit. One that ignores the wake rule misses the lower-limit offset.
- In interrupt mode, a clear pulse that lands in the same cycle as a flagging sample, and clear pulses in comparator mode. A wrong event latch either loses the new event or drops the comparator level.

// File: rtl/awe_pkg.sv
package awe_pkg;
    localparam int TEMP_W = 12;
    localparam int HYST_W = 6;
    localparam int WIDE_W = TEMP_W + 1;

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic [HYST_W-1:0]        hyst_t;

    typedef struct packed {
        logic below;
        logic above;
        logic crit;
    } flags_t;

    function automatic wide_t widen(input temp_t t);
        return {t[TEMP_W-1], t};
    endfunction

    function automatic wide_t lower_by(input temp_t thr, input hyst_t h, input logic en);
        wide_t off;
        off = en ? $signed({{(WIDE_W-HYST_W){1'b0}}, h}) : '0;
        return widen(thr) - off;
    endfunction
endpackage

// File: rtl/awe_trend.sv
module awe_trend
    import awe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shdn,
    input  logic  smp_vld,
    input  temp_t temp,
    output logic  apply_lo,
    output logic  apply_up
);
    logic  first_q;
    logic  fall_q;
    logic  fall_now;
    temp_t prev_q;

    always_comb begin
        if (temp < prev_q)      fall_now = 1'b1;
        else if (temp > prev_q) fall_now = 1'b0;
        else                    fall_now = fall_q;
        apply_lo = first_q | fall_now;
        apply_up = ~first_q & fall_now;
    end

    always_ff @(posedge clk) begin
        if (rst || shdn) begin
            first_q <= 1'b1;
            fall_q  <= 1'b0;
            prev_q  <= '0;
        end else if (smp_vld) begin
            first_q <= 1'b0;
            prev_q  <= temp;
            fall_q  <= first_q ? 1'b0 : fall_now;
        end
    end

    // R3: leaving shutdown always restarts the first-sample rule
    p_wake_first_r3: assert property (@(posedge clk) disable iff (rst)
        shdn |=> first_q);
    // R4: trend memory unchanged without a sample
    p_trend_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!shdn && !smp_vld) |=> ($stable(fall_q) && $stable(prev_q)));
endmodule

// File: rtl/awe_window.sv
module awe_window
    import awe_pkg::*;
(
    input  temp_t  temp,
    input  temp_t  lim_lo,
    input  temp_t  lim_hi,
    input  temp_t  lim_crit,
    input  hyst_t  hyst,
    input  logic   apply_lo,
    input  logic   apply_up,
    output flags_t nflags
);
    wide_t t_w;
    wide_t eff_lo;
    wide_t eff_hi;
    wide_t eff_cr;

    always_comb begin
        t_w          = widen(temp);
        eff_lo       = lower_by(lim_lo,   hyst, apply_lo);
        eff_hi       = lower_by(lim_hi,   hyst, apply_up);
        eff_cr       = lower_by(lim_crit, hyst, apply_up);
        nflags.below = t_w < eff_lo;
        nflags.above = t_w > eff_hi;
        nflags.crit  = t_w > eff_cr;
    end
endmodule

// File: rtl/awe_event.sv
module awe_event
    import awe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shdn,
    input  logic   smp_vld,
    input  logic   mode_intr,
    input  logic   clr_evt,
    input  flags_t nflags,
    output flags_t flags_q,
    output logic   evt_q
);
    logic cond;
    assign cond = |nflags;

    always_ff @(posedge clk) begin
        if (rst || shdn) begin
            flags_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            if (smp_vld) flags_q <= nflags;
            if (mode_intr)    evt_q <= (evt_q & ~clr_evt) | (smp_vld & cond);
            else if (smp_vld) evt_q <= cond;
        end
    end

    p_shdn_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (!evt_q && flags_q == '0));
    p_cmp_track_r6: assert property (@(posedge clk) disable iff (rst)
        (!shdn && !mode_intr && smp_vld) |=> (evt_q == $past(cond)));
    p_intr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!shdn && mode_intr && evt_q && !clr_evt) |=> evt_q);
    p_intr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (!shdn && mode_intr && clr_evt && !smp_vld) |=> !evt_q);
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!shdn && !smp_vld) |=> $stable(flags_q));
endmodule

// File: rtl/alarm_window_evt.sv
module alarm_window_evt
    import awe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] lim_lo,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic [TEMP_W-1:0] lim_crit,
    input  logic [HYST_W-1:0] hyst,
    input  logic              mode_intr,
    input  logic              shdn,
    input  logic              clr_evt,
    output logic              flag_below,
    output logic              flag_above,
    output logic              flag_crit,
    output logic              evt_out,
    output logic              evt_status
);
    logic   apply_lo;
    logic   apply_up;
    flags_t nflags;
    flags_t flags_q;
    logic   evt_q;

    awe_trend u_trend (
        .clk(clk), .rst(rst), .shdn(shdn), .smp_vld(smp_vld),
        .temp(temp_t'(temp)), .apply_lo(apply_lo), .apply_up(apply_up)
    );

    awe_window u_window (
        .temp(temp_t'(temp)), .lim_lo(temp_t'(lim_lo)), .lim_hi(temp_t'(lim_hi)),
        .lim_crit(temp_t'(lim_crit)), .hyst(hyst),
        .apply_lo(apply_lo), .apply_up(apply_up), .nflags(nflags)
    );

    awe_event u_event (
        .clk(clk), .rst(rst), .shdn(shdn), .smp_vld(smp_vld),
        .mode_intr(mode_intr), .clr_evt(clr_evt), .nflags(nflags),
        .flags_q(flags_q), .evt_q(evt_q)
    );

    assign flag_below = flags_q.below;
    assign flag_above = flags_q.above;
    assign flag_crit  = flags_q.crit;
    assign evt_out    = evt_q;
    assign evt_status = evt_q;

    // R1: everything low right after reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!evt_out && !flag_below && !flag_above && !flag_crit));
endmodule

// File: tb/alarm_window_evt_test.sv
module alarm_window_evt_test;
    localparam int TW = 12;
    localparam int HW = 6;

    logic clk = 1'b0;
    logic rst, smp_vld, mode_intr, shdn, clr_evt;
    logic [TW-1:0] temp, lim_lo, lim_hi, lim_crit;
    logic [HW-1:0] hyst;
    logic flag_below, flag_above, flag_crit, evt_out, evt_status;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int  m_prev;
    bit  m_fall, m_first, mb, ma, mc, me;

    always #4 clk = ~clk;

    alarm_window_evt uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .temp(temp),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .lim_crit(lim_crit), .hyst(hyst),
        .mode_intr(mode_intr), .shdn(shdn), .clr_evt(clr_evt),
        .flag_below(flag_below), .flag_above(flag_above), .flag_crit(flag_crit),
        .evt_out(evt_out), .evt_status(evt_status)
    );

    function automatic int sx(input logic [TW-1:0] v);
        return int'($signed(v));
    endfunction

    always @(posedge clk) begin
        int t, h, elo, ehi, ecr;
        bit nb, na, nc, fall;
        started <= 1'b1;
        if (rst || shdn) begin
            mb = 0; ma = 0; mc = 0; me = 0;
            m_first = 1; m_fall = 0; m_prev = 0;
        end else begin
            t = sx(temp); h = int'(hyst);
            nb = 0; na = 0; nc = 0;
            if (smp_vld) begin
                if (m_first) begin
                    elo = sx(lim_lo) - h; ehi = sx(lim_hi); ecr = sx(lim_crit);
                end else begin
                    if (t < m_prev) fall = 1;
                    else if (t > m_prev) fall = 0;
                    else fall = m_fall;
                    m_fall = fall;
                    elo = sx(lim_lo)   - (fall ? h : 0);
                    ehi = sx(lim_hi)   - (fall ? h : 0);
                    ecr = sx(lim_crit) - (fall ? h : 0);
                end
                nb = t < elo; na = t > ehi; nc = t > ecr;
                mb = nb; ma = na; mc = nc;
                m_prev = t; m_first = 0;
            end
            if (mode_intr) me = (me && !clr_evt) || (smp_vld && (nb || na || nc));
            else if (smp_vld) me = nb || na || nc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference comparison on every cycle (covers R1..R10, R8 through evt_status)
    always @(negedge clk) begin
        if (started) begin
            chk({flag_below, flag_above, flag_crit, evt_out} === {mb, ma, mc, me},
                cur_req, int'({flag_below, flag_above, flag_crit, evt_out}),
                int'({mb, ma, mc, me}));
            chk(evt_status === evt_out, "R8", int'(evt_status), int'(evt_out));
        end
    end

    task automatic samp(input int t, input int exp_evt);
        @(negedge clk);
        smp_vld = 1; temp = TW'(t);
        @(negedge clk);
        smp_vld = 0; temp = TW'(t + 17);
        chk(evt_out === exp_evt[0], {cur_req, " R9"}, int'(evt_out), exp_evt);
    endtask

    task automatic pulse_clr(input int exp_evt);
        @(negedge clk);
        clr_evt = 1;
        @(negedge clk);
        clr_evt = 0;
        chk(evt_out === exp_evt[0], cur_req, int'(evt_out), exp_evt);
    endtask

    task automatic sleep_wake();
        @(negedge clk); shdn = 1;
        @(negedge clk); smp_vld = 1; temp = TW'(120);
        @(negedge clk); smp_vld = 0;
        chk(evt_out === 1'b0, "R2", int'(evt_out), 0);
        shdn = 0;
        repeat (3) @(negedge clk);
        chk(evt_out === 1'b0, "R2", int'(evt_out), 0);
    endtask

    initial begin
        rst = 1; smp_vld = 0; mode_intr = 0; shdn = 0; clr_evt = 0;
        temp = '0; lim_lo = TW'(10); lim_hi = TW'(80); lim_crit = TW'(100); hyst = HW'(6);
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk({flag_below, flag_above, flag_crit, evt_out, evt_status} === 5'b0, "R1",
            int'({flag_below, flag_above, flag_crit, evt_out}), 0);
        rst = 0;

        cur_req = "R3"; samp(7, 0);
        cur_req = "R5"; samp(10, 0); samp(9, 0); samp(3, 1);
        cur_req = "R6"; pulse_clr(1);
        cur_req = "R4"; samp(81, 1); samp(78, 1); samp(78, 1); samp(74, 0); samp(79, 0);
        samp(101, 1); samp(97, 1);
        cur_req = "R2"; sleep_wake();
        cur_req = "R3"; samp(3, 1); samp(5, 1);
        cur_req = "R2"; sleep_wake();
        cur_req = "R3"; samp(78, 0);
        cur_req = "R4"; samp(77, 1);
        cur_req = "R7"; mode_intr = 1;
        samp(50, 1); pulse_clr(0); samp(50, 0); samp(85, 1); samp(50, 1);
        pulse_clr(0);
        @(negedge clk); clr_evt = 1; smp_vld = 1; temp = TW'(85);
        @(negedge clk); clr_evt = 0; smp_vld = 0;
        chk(evt_out === 1'b1, "R7", int'(evt_out), 1);
        pulse_clr(0);
        cur_req = "R10";
        repeat (10) begin
            @(negedge clk); temp = TW'($urandom_range(0, 200));
        end

        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            smp_vld   = ($urandom_range(0, 2) != 0);
            temp      = TW'(int'($urandom_range(0, 200)) - 50);
            clr_evt   = ($urandom_range(0, 5) == 0);
            shdn      = ($urandom_range(0, 30) == 0);
            if ($urandom_range(0, 40) == 0) mode_intr = ~mode_intr;
            if ($urandom_range(0, 60) == 0) hyst = HW'($urandom_range(0, 63));
        end
        @(negedge clk); smp_vld = 0; clr_evt = 0; shdn = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule